// File: doc/BRIEF.md
# Master Clock Source Selector and Two-Stage Divider

This block turns four candidate clock streams into two derived clocks for the rest of the chip: a processor clock and a slower master (bus) clock. Every clock is carried as a single-cycle enable pulse in one system clock domain, so source selection is plain logic rather than a real clock multiplexer. The four candidates are a slow clock, the main oscillator clock, and the outputs of two PLLs.

Software writes one control word that holds a source selector and two division settings. The selected pulse stream first passes through a power-of-two prescaler, and the result is the processor clock. That stream is then divided again by a small integer to give the master clock. A ready flag in a status word drops whenever the control word is written. It comes back once the master clock has produced its first pulse under the new settings. Any write to the control word restarts both division counters, so a stale count cannot emit a pulse early or twice.

Top module: `mclk_top`

## Requirements
- R1: After reset the control word reads zero (slow clock selected, both dividers zero) and `busReady` is 1.
- R2: Control bits 1:0 select the source pulse stream: 0 takes `srcTick[0]` (slow clock), 1 takes `srcTick[1]` (main clock), 2 takes `srcTick[2]` (PLL A) and 3 takes `srcTick[3]` (PLL B).
- R3: With prescaler value p in control bits 3:2, `cpuTick` pulses in the same cycle as every 2^p-th selected source pulse.
- R4: With divider value m in control bits 9:8, `busTick` pulses in the same cycle as every (m+1)-th `cpuTick`, and never without `cpuTick`.
- R5: With p=0 and m=0, `busTick` equals the selected source pulse stream, cycle for cycle.
- R6: A write to the control word (address 0) makes `busReady` 0 from the next cycle. The status word (address 1) shows `busReady` at bit 3, and all its other bits read as zero.
- R7: `busReady` becomes 1 in the cycle after the first `busTick` that follows a control write, provided no further control write comes in between.
- R8: A control write restarts both counters. A source pulse in the write cycle is handled under the old settings and is not counted under the new ones. The first `cpuTick` after the write falls on the 2^p-th selected pulse after the write cycle.
- R9: Reading address 0 returns the stored select, prescaler and divider fields at bits 1:0, 3:2 and 9:8, with every other bit zero.
- R10: Writes to any address other than 0 change neither the control word nor the outputs, and reads from addresses other than 0 and 1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | 4 | Candidate clock enables: slow, main, PLL A, PLL B |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (2) | Register address (0 control, 1 status) |
| regWrData | input | DATA_W (32) | Register write data |
| regRdData | output | DATA_W (32) | Combinational read data for `regAddr` |
| cpuTick | output | 1 | Processor clock enable pulse |
| busTick | output | 1 | Master clock enable pulse |
| busReady | output | 1 | Master clock ready flag |

## Verification
The bench targets four corner cases:

- **Source pulse in the write cycle.** A design that counted this pulse under the new settings would emit the first processor pulse one source pulse early.
- **Back-to-back control writes.** A design that let a master pulse from the old configuration set the ready flag would report ready before the new settings had taken effect.
- **Full divider range.** Switching between the slowest and the pass-through settings exposes a prescaler limit that is off by one or that fails to decode the largest exponent. Either fault gives a wrong pulse spacing.
- **Dense source streams.** Runs where a source pulses every cycle show whether the master clock degrades into a copy of the processor clock.

Writes to unmapped addresses and all-ones control writes check that stray bits neither stick in the readback nor disturb the pulse streams.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  // Number of candidate source clocks and derived field widths
  localparam int SRC_N     = 4;
  localparam int SEL_W     = $clog2(SRC_N);
  localparam int PRE_W     = 2;
  localparam int DIV_W     = 2;
  // Prescaler counter must reach 2^pmax - 1
  localparam int PRE_CNT_W = (1 << PRE_W) - 1;
  localparam int DIV_CNT_W = DIV_W;

  // Control word layout (software visible)
  localparam int SEL_LSB   = 0;
  localparam int PRE_LSB   = 2;
  localparam int DIV_LSB   = 8;
  // Status word layout
  localparam int READY_BIT = 3;

  // Register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;

  // Strobes and settings handed from control to datapath
  typedef struct packed {
    logic             restart;
    logic [SEL_W-1:0] sel;
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } cfgStrobe_t;
endpackage

// File: rtl/mclk_ctrl.sv
module mclk_ctrl
  import mclk_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busTick,
  output cfgStrobe_t        cfg,
  output logic [DATA_W-1:0] regRdData,
  output logic              busReady
);
  logic [SEL_W-1:0] selQ;
  logic [PRE_W-1:0] preQ;
  logic [DIV_W-1:0] divQ;
  logic             readyQ;
  logic             ctrlWrite;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] statWord;

  assign ctrlWrite = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));

  // Stored configuration fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      preQ <= '0;
      divQ <= '0;
    end else if (ctrlWrite) begin
      selQ <= regWrData[SEL_LSB +: SEL_W];
      preQ <= regWrData[PRE_LSB +: PRE_W];
      divQ <= regWrData[DIV_LSB +: DIV_W];
    end
  end

  // Ready: a write clears it, first master pulse afterwards sets it
  always_ff @(posedge clk) begin
    if (!rstN)          readyQ <= 1'b1;
    else if (ctrlWrite) readyQ <= 1'b0;
    else if (busTick)   readyQ <= 1'b1;
  end

  // Strobe bundle to the datapath
  always_comb begin
    cfg.restart = ctrlWrite;
    cfg.sel     = selQ;
    cfg.pre     = preQ;
    cfg.div     = divQ;
  end

  // Readback words, unused bits zero
  always_comb begin
    ctrlWord = '0;
    ctrlWord[SEL_LSB +: SEL_W] = selQ;
    ctrlWord[PRE_LSB +: PRE_W] = preQ;
    ctrlWord[DIV_LSB +: DIV_W] = divQ;
    statWord = '0;
    statWord[READY_BIT] = readyQ;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_W'(ADDR_CTRL): regRdData = ctrlWord;
      ADDR_W'(ADDR_STAT): regRdData = statWord;
      default:            regRdData = '0;
    endcase
  end

  assign busReady = readyQ;
endmodule

// File: rtl/mclk_datapath.sv
module mclk_datapath
  import mclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] srcTick,
  input  cfgStrobe_t       cfg,
  output logic             cpuTick,
  output logic             busTick
);
  logic [SRC_N-1:0]     selHit;
  logic                 srcPulse;
  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preLim;
  logic [DIV_CNT_W-1:0] divCnt;
  logic                 preWrap;
  logic                 divWrap;

  // AND-OR source selection, one lane per candidate
  for (genvar g = 0; g < SRC_N; g++) begin : gSrcLane
    assign selHit[g] = srcTick[g] && (cfg.sel == SEL_W'(g));
  end
  assign srcPulse = |selHit;

  // Prescaler limit 2^p - 1 as a thermometer code
  always_comb begin
    for (int b = 0; b < PRE_CNT_W; b++) begin
      preLim[b] = (int'(cfg.pre) > b);
    end
  end

  assign preWrap = (preCnt == preLim);
  assign divWrap = (divCnt == DIV_CNT_W'(cfg.div));
  assign cpuTick = srcPulse && preWrap;
  assign busTick = cpuTick && divWrap;

  // Power-of-two prescaler counter
  always_ff @(posedge clk) begin
    if (!rstN || cfg.restart) preCnt <= '0;
    else if (srcPulse)        preCnt <= preWrap ? '0 : preCnt + 1'b1;
  end

  // Divide-by-(m+1) counter on processor pulses
  always_ff @(posedge clk) begin
    if (!rstN || cfg.restart) divCnt <= '0;
    else if (cpuTick)         divCnt <= divWrap ? '0 : divCnt + 1'b1;
  end
endmodule

// File: rtl/mclk_top.sv
module mclk_top
  import mclk_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              cpuTick,
  output logic              busTick,
  output logic              busReady
);
  cfgStrobe_t cfgBus;

  mclk_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .busTick  (busTick),
    .cfg      (cfgBus),
    .regRdData(regRdData),
    .busReady (busReady)
  );

  mclk_datapath uPath (
    .clk    (clk),
    .rstN   (rstN),
    .srcTick(srcTick),
    .cfg    (cfgBus),
    .cpuTick(cpuTick),
    .busTick(busTick)
  );
endmodule

// File: rtl/mclk_checker.sv
module mclk_checker
  import mclk_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [SRC_N-1:0]  srcTick,
  input cfgStrobe_t        cfg,
  input logic              cpuTick,
  input logic              busTick,
  input logic              busReady
);
  logic wrCtrl;
  assign wrCtrl = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> !busReady);

  a_r7_ready_needs_bus: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReady) |-> $past(busTick));

  a_r4_bus_inside_cpu: assert property (@(posedge clk) disable iff (!rstN)
    busTick |-> cpuTick);

  a_r2_cpu_from_selected: assert property (@(posedge clk) disable iff (!rstN)
    cpuTick |-> srcTick[cfg.sel]);

  a_r5_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.pre == '0 && cfg.div == '0) |-> (busTick == srcTick[cfg.sel]));

  a_r8_restart_prescale: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (cpuTick |-> cfg.pre == '0));
endmodule

bind mclk_top mclk_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .srcTick (srcTick),
  .cfg     (cfgBus),
  .cpuTick (cpuTick),
  .busTick (busTick),
  .busReady(busReady)
);

// File: tb/sim_mclk_top.sv
module sim_mclk_top;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [3:0]        srcTick = '0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic              cpuTick, busTick, busReady;

  mclk_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cpuTick(cpuTick), .busTick(busTick), .busReady(busReady)
  );

  always #(PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Behavioural reference state
  int mSel, mPre, mDiv, mPreCnt, mDivCnt, mReady;

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] expRead(int addr);
    if (addr == 0) return DATA_W'(mSel | (mPre << 2) | (mDiv << 8));
    if (addr == 1) return DATA_W'(mReady << 3);
    return '0;
  endfunction

  // Reference model, compared on every clock away from the edge
  always @(negedge clk) begin
    if (!rstN) begin
      mSel = 0; mPre = 0; mDiv = 0; mPreCnt = 0; mDivCnt = 0; mReady = 1;
    end else begin
      bit src, cpu, bus;
      src = srcTick[mSel];
      cpu = src && (mPreCnt == (1 << mPre) - 1);
      bus = cpu && (mDivCnt == mDiv);
      chk("R3 cpuTick", DATA_W'(cpuTick), DATA_W'(cpu));
      chk("R4 busTick", DATA_W'(busTick), DATA_W'(bus));
      chk("R7 busReady", DATA_W'(busReady), DATA_W'(mReady));
      if (regAddr == 0)      chk("R9 ctrl readback", regRdData, expRead(0));
      else if (regAddr == 1) chk("R6 status word", regRdData, expRead(1));
      else                   chk("R10 unmapped read", regRdData, expRead(int'(regAddr)));
      if (regWrEn && regAddr == 0) begin
        mSel = int'(regWrData[1:0]);
        mPre = int'(regWrData[3:2]);
        mDiv = int'(regWrData[9:8]);
        mPreCnt = 0; mDivCnt = 0; mReady = 0;
      end else begin
        if (src) mPreCnt = cpu ? 0 : mPreCnt + 1;
        if (cpu) mDivCnt = bus ? 0 : mDivCnt + 1;
        if (bus) mReady = 1;
      end
    end
  end

  // Drive one cycle of source pulses; each lane fires with odds 1/density
  task automatic drive(int density);
    for (int b = 0; b < 4; b++) srcTick[b] = ($urandom_range(density - 1) == 0);
  endtask

  task automatic run(int n, int density);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      drive(density);
    end
  endtask

  task automatic regWrite(int addr, logic [DATA_W-1:0] data, int density);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = ADDR_W'(addr); regWrData = data;
    drive(density);
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    drive(density);
  endtask

  function automatic logic [DATA_W-1:0] cfgWord(int s, int p, int m);
    return DATA_W'(s | (p << 2) | (m << 8));
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset ctrl", regRdData, '0);
    chk("R1 reset ready", DATA_W'(busReady), 1);

    // R5: pass-through on slow clock, then on every source (R2)
    run(40, 2);
    for (int s = 0; s < 4; s++) begin
      regWrite(0, cfgWord(s, 0, 0), 2);
      run(30, 2);
    end

    // R2/R3/R4: sweep prescaler and divider on each source
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        for (int m = 0; m < 4; m++) begin
          regWrite(0, cfgWord(s, p, m), 1 + (s + p) % 3);
          run(12 * (1 << p) * (m + 1), 1 + (s + p) % 3);
        end
      end
    end

    // R8/R7: back-to-back writes with dense sources, pulses in write cycle
    for (int k = 0; k < 20; k++) begin
      regWrite(0, cfgWord(k % 4, (k + 1) % 4, k % 3), 1);
      regWrite(0, cfgWord((k + 2) % 4, k % 2, (k + 1) % 4), 1);
      run(k % 7, 1);
    end
    run(200, 1);

    // R9: all-ones write keeps only defined fields
    regWrite(0, '1, 3);
    @(negedge clk);
    chk("R9 all-ones readback", regRdData, DATA_W'(32'h30F));
    run(100, 2);

    // R10: writes elsewhere ignored, unmapped reads zero
    regWrite(2, '1, 2);
    regWrite(1, '0, 2);
    regWrite(3, 32'h0000_0101, 2);
    @(negedge clk);
    chk("R10 ctrl after stray writes", regRdData, DATA_W'(32'h30F));
    run(80, 2);

    // R6: watch the status word across a reconfiguration
    @(posedge clk); #1 regAddr = 2'd1;
    run(10, 1);
    @(negedge clk);
    chk("R6 ready set before write", regRdData, DATA_W'(32'h8));
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = cfgWord(1, 3, 3);
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = 2'd1; srcTick = '0;
    @(negedge clk);
    chk("R6 ready cleared by write", regRdData, '0);
    run(200, 1);
    @(negedge clk);
    chk("R7 ready restored", regRdData, DATA_W'(32'h8));
    @(posedge clk); #1 regAddr = '0;
    run(20, 1);

    finish();
  end
endmodule